// File: doc/BRIEF.md
# Per-Channel Converter Fault Supervisor

This block supervises one switching-regulator channel. It watches four comparator outputs that are already synchronised to its clock: overvoltage entry, overvoltage recovery, undervoltage and overcurrent. From these it decides whether the channel's high-side and low-side gate drivers may run and whether power-good is shown. It also keeps a sticky record of every fault and asks for a chip-level soft reset after an over-temperature shutdown ends.

Fault detection is suspended while the channel is soft-starting and while its reference is being moved. A blanking window follows each reference move. Voltage faults must persist for a programmable deglitch time before they count. After an overvoltage clears, the low-side driver alone is enabled for a fixed recharge time before normal switching returns. Each channel has its own instance, so a fault in one channel leaves the others untouched.

All times are parameters in clock cycles: `DGL_CYC` for the deglitch time, `BLANK_CYC` for post-ramp blanking and `BOOT_CYC` for the recharge pulse.

Top module: `fault_supervisor`

## Requirements
- R1: After reset, both gate enables and power-good are high, the status vector is zero and the soft-reset request is low.
- R2: An overvoltage is registered only at the clock edge that ends `DGL_CYC` consecutive cycles with `ov_rise_i` high and detection unmasked. A shorter run, or a masked cycle, restarts the count.
- R3: Once an overvoltage is registered, both gate enables stay low until `ov_fall_i` is seen high.
- R4: The cycle after `ov_fall_i` is seen in the overvoltage-off state, only the low-side enable is high, for exactly `BOOT_CYC` cycles. After that both enables return.
- R5: An undervoltage held for `DGL_CYC` unmasked cycles drops power-good without touching the gate enables. Power-good returns the cycle after `uv_i` goes low.
- R6: While `oc_i` is high and detection is unmasked, `hs_en_o` is low in the same cycle, and the overcurrent status bit is set.
- R7: While `ss_active_i` is high (and no over-temperature is present), the detectors are held unfaulted. Overvoltage-off and recharge return to normal, the undervoltage flag clears and deglitch counts restart.
- R8: Detection is masked while `ref_ramp_i` is high, in the cycle of the `ref_settled_i` pulse, and for `BLANK_CYC` cycles after it. A fault that is held throughout is registered `BLANK_CYC + DGL_CYC` edges after the pulse edge.
- R9: `ot_i` forces both gates off and power-good low from the next cycle, overriding every other state. When `ot_i` falls, `soft_rst_req_o` pulses high for one cycle and switching resumes.
- R10: The status bits are sticky: bit 0 overvoltage, bit 1 undervoltage, bit 2 overcurrent, bit 3 over-temperature. Each bit clears on a one in the same position of `sts_clr_i`, and a new event in the same cycle wins over the clear.
- R11: Two instances share nothing. Faults driven into one instance never change the outputs of the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ov_rise_i | input | 1 | Overvoltage entry comparator |
| ov_fall_i | input | 1 | Overvoltage recovery comparator |
| uv_i | input | 1 | Undervoltage comparator |
| oc_i | input | 1 | Overcurrent comparator |
| ss_active_i | input | 1 | Channel soft-start in progress |
| ref_ramp_i | input | 1 | Reference ramp in progress |
| ref_settled_i | input | 1 | One-cycle pulse when the ramp reaches its target |
| ot_i | input | 1 | Shared over-temperature flag |
| sts_clr_i | input | 4 | Write-one-to-clear pulses for the status bits |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| pgood_o | output | 1 | Power-good |
| sts_o | output | 4 | Sticky fault status |
| soft_rst_req_o | output | 1 | Soft-reset request after over-temperature |

## Verification
The hardest case to reach is the exact edge at which a fault held through a reference move is registered. The bench holds `ov_rise_i` high through the ramp and the settle pulse and for the whole blanking window, then checks one edge before and at `BLANK_CYC + DGL_CYC`. Random glitch lengths just under the deglitch time, with a soft-start pulse in the middle of a run, show that counts restart. Two instances, one driven with random faults and one held quiet, show that the channels are isolated.

// File: rtl/fault_supervisor.sv
module fault_supervisor #(
  parameter int DGL_CYC   = 11000,
  parameter int BLANK_CYC = 20000,
  parameter int BOOT_CYC  = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ov_rise_i,
  input  logic       ov_fall_i,
  input  logic       uv_i,
  input  logic       oc_i,
  input  logic       ss_active_i,
  input  logic       ref_ramp_i,
  input  logic       ref_settled_i,
  input  logic       ot_i,
  input  logic [3:0] sts_clr_i,
  output logic       hs_en_o,
  output logic       ls_en_o,
  output logic       pgood_o,
  output logic [3:0] sts_o,
  output logic       soft_rst_req_o
);
  localparam int DW = $clog2(DGL_CYC + 1);
  localparam int BW = $clog2(BLANK_CYC + 1);
  localparam int RW = $clog2(BOOT_CYC + 1);

  typedef enum logic [1:0] {NORMAL, OVP_OFF, BOOT_RECHARGE, OTP_OFF} gstate_t;

  gstate_t        state;
  logic [DW-1:0]  ov_cnt, uv_cnt;
  logic [BW-1:0]  blank_cnt;
  logic [RW-1:0]  boot_cnt;
  logic           uv_flag, srst_q;
  logic [3:0]     sts_q;

  wire masked = ss_active_i | ref_ramp_i | ref_settled_i | (blank_cnt != '0);
  wire ov_q   = ov_rise_i & ~masked & (state == NORMAL);
  wire ov_hit = ov_q && (ov_cnt == DW'(DGL_CYC - 1));
  wire uv_q   = uv_i & ~masked & ~uv_flag;
  wire uv_hit = uv_q && (uv_cnt == DW'(DGL_CYC - 1));
  wire oc_q   = oc_i & ~masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_cnt <= '0;
      ov_cnt    <= '0;
      uv_cnt    <= '0;
    end else begin
      if (ref_settled_i)        blank_cnt <= BW'(BLANK_CYC);
      else if (ref_ramp_i)      blank_cnt <= '0;
      else if (blank_cnt != '0) blank_cnt <= blank_cnt - 1'b1;
      ov_cnt <= (ov_q && !ov_hit) ? ov_cnt + 1'b1 : '0;
      uv_cnt <= (uv_q && !uv_hit) ? uv_cnt + 1'b1 : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= NORMAL;
      boot_cnt <= '0;
      srst_q   <= 1'b0;
    end else begin
      srst_q <= (state == OTP_OFF) && !ot_i;
      if (ot_i) begin
        state <= OTP_OFF;
      end else if (state == OTP_OFF) begin
        state <= NORMAL;
      end else if (ss_active_i) begin
        state <= NORMAL;
      end else begin
        case (state)
          NORMAL:  if (ov_hit) state <= OVP_OFF;
          OVP_OFF: if (ov_fall_i) begin
                     state    <= BOOT_RECHARGE;
                     boot_cnt <= '0;
                   end
          BOOT_RECHARGE:
            if (boot_cnt == RW'(BOOT_CYC - 1)) state <= NORMAL;
            else boot_cnt <= boot_cnt + 1'b1;
          default: state <= NORMAL;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_flag <= 1'b0;
      sts_q   <= '0;
    end else begin
      if (ss_active_i)  uv_flag <= 1'b0;
      else if (uv_hit)  uv_flag <= 1'b1;
      else if (!uv_i)   uv_flag <= 1'b0;
      sts_q <= (sts_q & ~sts_clr_i) | {ot_i, oc_q, uv_hit, ov_hit};
    end
  end

  assign hs_en_o        = (state == NORMAL) && !oc_q;
  assign ls_en_o        = (state == NORMAL) || (state == BOOT_RECHARGE);
  assign pgood_o        = !uv_flag && (state != OTP_OFF);
  assign sts_o          = sts_q;
  assign soft_rst_req_o = srst_q;
endmodule

module fault_supervisor_chk #(
  parameter int DGL_CYC   = 11000,
  parameter int BLANK_CYC = 20000,
  parameter int BOOT_CYC  = 40
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ov_rise_i,
  input logic       ov_fall_i,
  input logic       oc_i,
  input logic       ss_active_i,
  input logic       ref_ramp_i,
  input logic       ref_settled_i,
  input logic       ot_i,
  input logic [3:0] sts_clr_i,
  input logic       hs_en_o,
  input logic       ls_en_o,
  input logic       pgood_o,
  input logic [3:0] sts_o,
  input logic       soft_rst_req_o,
  input logic [1:0] state,
  input logic [$clog2(BLANK_CYC+1)-1:0] blank_cnt
);
  localparam logic [1:0] S_NORM = 2'd0, S_OVP = 2'd1, S_BOOT = 2'd2;
  logic [31:0] ovrun, bcnt;
  wire quiet = !ss_active_i && !ref_ramp_i && !ref_settled_i && (blank_cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovrun <= '0;
      bcnt  <= '0;
    end else begin
      ovrun <= (ov_rise_i && quiet && state == S_NORM && ovrun < DGL_CYC) ? ovrun + 1 : '0;
      bcnt  <= (state == S_BOOT) ? bcnt + 1 : '0;
    end
  end

  a_r2_full_run: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_OVP && $past(state) == S_NORM) |-> $past(ovrun) == DGL_CYC - 1);
  a_r3_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_OVP && !ov_fall_i && !ot_i && !ss_active_i) |=> (!hs_en_o && !ls_en_o));
  a_r4_boot_ls_only: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BOOT) |-> (ls_en_o && !hs_en_o && bcnt < BOOT_CYC));
  a_r4_boot_full: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == S_BOOT && state == S_NORM && !$past(ss_active_i)) |-> $past(bcnt) == BOOT_CYC - 1);
  a_r6_oc_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_i && quiet) |-> !hs_en_o);
  a_r7_ss_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (ss_active_i && !ot_i) |=> (state == S_NORM && pgood_o));
  a_r9_ot_off: assert property (@(posedge clk) disable iff (!rst_n)
    ot_i |=> (!hs_en_o && !ls_en_o && !pgood_o));
  a_r9_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_req_o |=> !soft_rst_req_o);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(sts_o) & ~$past(sts_clr_i) & ~sts_o) == 4'b0));
endmodule

bind fault_supervisor fault_supervisor_chk #(
  .DGL_CYC(DGL_CYC), .BLANK_CYC(BLANK_CYC), .BOOT_CYC(BOOT_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ov_rise_i(ov_rise_i), .ov_fall_i(ov_fall_i),
  .oc_i(oc_i), .ss_active_i(ss_active_i), .ref_ramp_i(ref_ramp_i),
  .ref_settled_i(ref_settled_i), .ot_i(ot_i), .sts_clr_i(sts_clr_i),
  .hs_en_o(hs_en_o), .ls_en_o(ls_en_o), .pgood_o(pgood_o), .sts_o(sts_o),
  .soft_rst_req_o(soft_rst_req_o), .state(state), .blank_cnt(blank_cnt)
);

// File: tb/fault_supervisor_bench.sv
`timescale 1ns/1ps
module fault_supervisor_bench;
  localparam int DGL = 6, BLK = 12, BOOT = 5;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic ovr, ovf, uv, oc, ss, ramp, setl, ot;
  logic [3:0] clr;
  logic hs, ls, pg, srst;
  logic [3:0] sts;
  logic b_ovr, b_ovf, b_uv, b_oc, b_ss;
  logic b_hs, b_ls, b_pg, b_srst;
  logic [3:0] b_sts;

  int checks = 0, errors = 0;

  fault_supervisor #(.DGL_CYC(DGL), .BLANK_CYC(BLK), .BOOT_CYC(BOOT)) u_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .ov_rise_i(ovr), .ov_fall_i(ovf), .uv_i(uv), .oc_i(oc),
    .ss_active_i(ss), .ref_ramp_i(ramp), .ref_settled_i(setl), .ot_i(ot), .sts_clr_i(clr),
    .hs_en_o(hs), .ls_en_o(ls), .pgood_o(pg), .sts_o(sts), .soft_rst_req_o(srst));

  fault_supervisor #(.DGL_CYC(DGL), .BLANK_CYC(BLK), .BOOT_CYC(BOOT)) u_fault_supervisor_b (
    .clk(clk), .rst_n(rst_n), .ov_rise_i(b_ovr), .ov_fall_i(b_ovf), .uv_i(b_uv), .oc_i(b_oc),
    .ss_active_i(b_ss), .ref_ramp_i(1'b0), .ref_settled_i(1'b0), .ot_i(1'b0), .sts_clr_i(4'b0),
    .hs_en_o(b_hs), .ls_en_o(b_ls), .pgood_o(b_pg), .sts_o(b_sts), .soft_rst_req_o(b_srst));

  function automatic bit ov_registers(int run_len);
    return run_len >= DGL;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic recover_ov();
    ovr = 0; ovf = 1; step(1); ovf = 0; step(BOOT);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed = 32'h1234;
    void'($urandom(seed));
    {ovr, ovf, uv, oc, ss, ramp, setl, ot} = '0; clr = 0;
    {b_ovr, b_ovf, b_uv, b_oc, b_ss} = '0;
    step(3); rst_n = 1; step(1);
    chk("R1 reset", {hs, ls, pg, srst, sts}, {4'b1110, 4'b0});

    // R2 random glitches shorter than the deglitch time
    for (int i = 0; i < 20; i++) begin
      int len = 1 + ($urandom % (DGL - 1));
      ovr = 1; step(len); ovr = 0; step(1);
      chk("R2 glitch ignored", {hs, ls, sts[0]}, {~ov_registers(len), ~ov_registers(len), ov_registers(len)});
    end
    ovr = 1; step(DGL - 1);
    chk("R2 not early", {hs, ls}, 2'b11);
    step(1);
    chk("R3 both off", {hs, ls, sts[0]}, 3'b001);
    ovr = 0; step(10);
    chk("R3 stays off", {hs, ls}, 2'b00);

    ovf = 1; step(1); ovf = 0;
    chk("R4 recharge start", {hs, ls}, 2'b01);
    step(BOOT - 1);
    chk("R4 recharge last", {hs, ls}, 2'b01);
    step(1);
    chk("R4 resume", {hs, ls}, 2'b11);

    clr = 4'b0001; step(1); clr = 0;
    chk("R10 w1c clear", sts, 4'b0000);

    uv = 1; step(DGL - 1);
    chk("R5 pgood early", pg, 1'b1);
    step(1);
    chk("R5 pgood low gates on", {pg, hs, ls, sts[1]}, 4'b0111);
    uv = 0; step(1);
    chk("R5 pgood back", pg, 1'b1);

    oc = 1; #1;
    chk("R6 hs cut", {hs, ls}, 2'b01);
    step(1);
    chk("R6 sticky", sts[2], 1'b1);
    oc = 0; #1;
    chk("R6 hs back", hs, 1'b1);
    oc = 1; clr = 4'b0100; step(1); oc = 0; clr = 0;
    chk("R10 set wins over clear", sts[2], 1'b1);
    clr = 4'b1111; step(1); clr = 0;

    ovr = 1; step(DGL); ss = 1; step(1);
    chk("R7 ss releases ovp", {hs, ls}, 2'b11);
    clr = 4'b0001; step(3 * DGL); clr = 0; step(1);
    chk("R7 masked in ss", {hs, ls, sts[0]}, 3'b110);
    ss = 0; step(DGL - 1); ss = 1; step(1); ss = 0; step(DGL - 1);
    chk("R7 count restarts", {hs, sts[0]}, 2'b10);
    ovr = 0; step(1);

    ramp = 1; ovr = 1; step(3 * DGL);
    chk("R8 masked in ramp", {hs, sts[0]}, 2'b10);
    ramp = 0; setl = 1; step(1); setl = 0;
    step(BLK + DGL - 1);
    chk("R8 blank window", {hs, sts[0]}, 2'b10);
    step(1);
    chk("R8 after blank", {hs, ls, sts[0]}, 3'b001);
    recover_ov(); step(1);
    chk("R4 recover again", {hs, ls}, 2'b11);

    ovr = 1; step(DGL); ot = 1; ovr = 0; step(1);
    chk("R9 ot overrides", {hs, ls, pg, sts[3]}, 4'b0001);
    ss = 1; step(4); ss = 0;
    chk("R9 ot priority over ss", {hs, ls, srst}, 3'b000);
    ot = 0; step(1);
    chk("R9 soft reset", {srst, hs, ls, pg}, 4'b1111);
    step(1);
    chk("R9 one pulse", srst, 1'b0);

    begin
      bit quiet_ok = 1, b_hit = 0;
      clr = 4'b1111; step(1); clr = 0;
      for (int c = 0; c < 2000; c++) begin
        b_ovr = ($urandom % 4) != 0; b_ovf = ($urandom % 8) == 0;
        b_uv  = ($urandom % 3) != 0; b_oc = ($urandom % 6) == 0;
        b_ss  = ($urandom % 50) == 0;
        step(1);
        if ({hs, ls, pg, srst, sts} !== {4'b1110, 4'b0}) quiet_ok = 0;
        if (b_sts != 0) b_hit = 1;
      end
      chk("R11 quiet channel untouched", quiet_ok, 1'b1);
      chk("R11 other channel faulted", b_hit, 1'b1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule